// File: doc/BRIEF.md
# Paged NIC Control Register Bank

This block is the byte-wide host register window of a network controller. The host reaches sixteen offsets. Offset 0 always holds the command register. The two top bits of that register pick a page, and the page decides what offsets 1 to 15 reach. The same offset can also reach one register on a write and a different one on a read.

The bank holds these settings:
- the receive ring pointers: first page, last page plus one, boundary and current page;
- the transmit page and byte count;
- the remote DMA address and byte count;
- the receive and data configuration bytes;
- the station address and the multicast hash bytes.

Every setting is also driven onto side-band outputs for the transmit, receive and remote-DMA datapaths, which are outside this block. Those datapaths report back through event inputs and a transmit-done strobe. The bank keeps the interrupt status and mask registers and drives a level interrupt line.

Ring-pointer writes are checked against the end of buffer memory, which is a parameter. A write that would point past that end is dropped.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command register reads 0x01 (stop, page 0). The interrupt status reads 0x80 (bit 7 = reset done). The mask is 0 and `irq_o` is low.
- R2: Command bits 7:6 select the page for offsets 1-15: 0, 1 or 2.
  - Page 1: offsets 1-6 read and write the station address bytes, offset 7 the current page, and offsets 8-15 the hash bytes.
  - Writing one page leaves registers on other pages untouched.
- R3: A write to page 0 offset 7 clears each interrupt status bit whose written bit is 1, for bits 6:0 only. Bit 7 is never cleared this way.
- R4: `irq_o` is high exactly when status AND mask AND 0x7F is nonzero. Status bit 7 therefore never raises it.
- R5: A command write with bit 0 (stop) clear clears status bit 7.
- R6: A command write with bit 0 clear and bit 3 (remote read) or bit 4 (remote write) set sets status bit 6 (remote DMA done) when the remote byte count is 0. No other command write sets bit 6.
- R7: Range checks on ring-pointer writes:
  - Page 0 writes to offset 1 (ring first page) and offset 2 (ring last page) are dropped when the value exceeds `MEM_END_PG`.
  - Page 0 offset 3 (boundary) and page 1 offset 7 (current page) are dropped when the value is `MEM_END_PG` or higher.
- R8: The 16-bit transmit count, remote address and remote count are written as a low byte and a high byte. Each byte write keeps the other byte.
  - Remote address: low byte at page 0 offset 8, high byte at offset 9.
  - Remote count: low byte at page 0 offset 10, high byte at offset 11.
  - Remote address reads back at the same offsets.
- R9: Page 0 reads of offset 10 return 0x50 and offset 11 return 0x43. Reads of undecoded offsets, and every page-3 read of offsets 1-15, return 0.
- R10: Page 2 reads of offset 1 and offset 2 return the ring first and last pages.
- R11: Transmit start and completion:
  - A command write with bit 2 (transmit) set and bit 0 clear gives `tx_start_o` for exactly one cycle, in the cycle after the write.
  - `tx_done_i` sets the transmit status (page 0 offset 4) to 0x01 and sets status bit 1. It also clears command bit 2.
- R12: Each `evt_i[k]` pulse sets status bit k. A set wins over a clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for `addr_i` on the current page |
| evt_i | input | 7 | Datapath event pulses that set status bits 6:0 |
| tx_done_i | input | 1 | Transmit completion strobe |
| tx_start_o | output | 1 | One-cycle transmit request |
| irq_o | output | 1 | Interrupt line |
| cmd_o | output | 8 | Command register |
| ring_start_o | output | 8 | Ring first page |
| ring_stop_o | output | 8 | Ring last page plus one |
| ring_bnd_o | output | 8 | Ring boundary page |
| ring_cur_o | output | 8 | Ring current page |
| tx_page_o | output | 8 | Transmit start page |
| tx_len_o | output | 16 | Transmit byte count |
| rdma_addr_o | output | 16 | Remote DMA address |
| rdma_len_o | output | 16 | Remote DMA byte count |
| rx_cfg_o | output | 8 | Receive configuration |
| data_cfg_o | output | 8 | Data configuration |
| sta_addr_o | output | 48 | Station address, byte k in bits 8k+7:8k |
| mcast_hash_o | output | 64 | Multicast hash, byte k in bits 8k+7:8k |

## Verification
The hardest corner to reach from the ports is the remote-DMA-done shortcut. It only fires on a command write that has stop clear, requests a remote transfer, and finds a byte count of zero. The stimulus covers all three conditions:
- It clears the count and issues a remote-read command, then checks that bit 6 is set.
- It repeats the command with a nonzero count loaded, then checks that bit 6 stays clear.
- It repeats it with the stop bit set, then checks that bit 6 stays clear.

The other hard corner is the range checks sitting next to page switching. Page 1 and page 2 are reached by rewriting the command register between writes. Every dropped pointer write is followed by a read on the page that exposes it.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {PG_0 = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;

  // command bits
  localparam int unsigned CMD_STOP  = 0;
  localparam int unsigned CMD_TX    = 2;
  localparam int unsigned CMD_RRD   = 3;
  localparam int unsigned CMD_RWR   = 4;

  // interrupt status bits
  localparam int unsigned IS_TX  = 1;
  localparam int unsigned IS_RDC = 6;
  localparam int unsigned IS_RST = 7;
  localparam int unsigned N_EVT  = 7;

  // page 0 offsets
  localparam logic [3:0] OF_START = 4'h1;
  localparam logic [3:0] OF_STOP  = 4'h2;
  localparam logic [3:0] OF_BND   = 4'h3;
  localparam logic [3:0] OF_TPG   = 4'h4;
  localparam logic [3:0] OF_TLO   = 4'h5;
  localparam logic [3:0] OF_THI   = 4'h6;
  localparam logic [3:0] OF_ISR   = 4'h7;
  localparam logic [3:0] OF_ALO   = 4'h8;
  localparam logic [3:0] OF_AHI   = 4'h9;
  localparam logic [3:0] OF_CLO   = 4'hA;
  localparam logic [3:0] OF_CHI   = 4'hB;
  localparam logic [3:0] OF_RXC   = 4'hC;
  localparam logic [3:0] OF_DCF   = 4'hE;
  localparam logic [3:0] OF_IMR   = 4'hF;

  localparam int unsigned STA_BASE = 1;
  localparam byte_t ID_LO = 8'h50;
  localparam byte_t ID_HI = 8'h43;
  localparam byte_t CMD_RST_VAL = 8'h01;
  localparam byte_t ISR_RST_VAL = 8'h80;
endpackage

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
  import nic_regbank_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  byte_t wdata_i,
  input  logic  tx_done_i,
  output byte_t cmd_o,
  output logic  tx_start_o
);
  byte_t cmd_q;
  logic  tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_RST_VAL;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= we_i && wdata_i[CMD_TX] && !wdata_i[CMD_STOP];
      if (we_i)           cmd_q <= wdata_i;
      else if (tx_done_i) cmd_q[CMD_TX] <= 1'b0;
    end
  end

  assign cmd_o      = cmd_q;
  assign tx_start_o = tx_q;
endmodule

// File: rtl/nic_int_ctl.sv
module nic_int_ctl
  import nic_regbank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  byte_t            cmd_wdata_i,
  input  logic             rcnt_zero_i,
  input  logic             clr_we_i,
  input  byte_t            clr_mask_i,
  input  logic             imr_we_i,
  input  byte_t            imr_wdata_i,
  input  logic [N_EVT-1:0] set_i,
  output byte_t            isr_o,
  output logic             irq_o
);
  byte_t isr_q, imr_q, set_v, clr_v;
  logic  run_cmd;

  assign run_cmd = cmd_we_i && !cmd_wdata_i[CMD_STOP];

  always_comb begin
    set_v = {1'b0, set_i};
    clr_v = clr_we_i ? {1'b0, clr_mask_i[N_EVT-1:0]} : 8'h00;
    if (run_cmd) begin
      clr_v[IS_RST] = 1'b1;
      if ((cmd_wdata_i[CMD_RRD] || cmd_wdata_i[CMD_RWR]) && rcnt_zero_i)
        set_v[IS_RDC] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= ISR_RST_VAL;
      imr_q <= 8'h00;
    end else begin
      isr_q <= (isr_q & ~clr_v) | set_v;
      if (imr_we_i) imr_q <= imr_wdata_i;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = |(isr_q & imr_q & 8'h7F);
endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
  import nic_regbank_pkg::*;
#(
  parameter byte_t       MEM_END_PG = 8'hC0,
  parameter int unsigned N_STA      = 6,
  parameter int unsigned N_HASH     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  page_e                   page_i,
  input  logic [3:0]              addr_i,
  input  byte_t                   wdata_i,
  input  logic                    tx_done_i,
  output byte_t                   start_o,
  output byte_t                   stop_o,
  output byte_t                   bnd_o,
  output byte_t                   cur_o,
  output byte_t                   tpg_o,
  output logic [15:0]             tcnt_o,
  output logic [15:0]             rsar_o,
  output logic [15:0]             rcnt_o,
  output byte_t                   rxc_o,
  output byte_t                   dcf_o,
  output byte_t                   tsr_o,
  output logic [N_STA-1:0][7:0]   sta_o,
  output logic [N_HASH-1:0][7:0]  hash_o
);
  localparam int unsigned CUR_OFF   = STA_BASE + N_STA;
  localparam int unsigned HASH_BASE = CUR_OFF + 1;

  logic  w0, w1, fit_incl, fit_excl;
  byte_t start_q, stop_q, bnd_q, cur_q, tpg_q, rxc_q, dcf_q, tsr_q;
  logic [15:0] tcnt_q, rsar_q, rcnt_q;
  logic [N_STA-1:0][7:0]  sta_q;
  logic [N_HASH-1:0][7:0] hash_q;

  assign w0 = we_i && (page_i == PG_0);
  assign w1 = we_i && (page_i == PG_1);
  assign fit_incl = (wdata_i <= MEM_END_PG);
  assign fit_excl = (wdata_i <  MEM_END_PG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0; stop_q <= '0; bnd_q <= '0; cur_q <= '0;
      tpg_q <= '0; rxc_q <= '0; dcf_q <= '0; tsr_q <= '0;
      tcnt_q <= '0; rsar_q <= '0; rcnt_q <= '0;
    end else begin
      if (tx_done_i) tsr_q <= 8'h01;
      if (w1 && addr_i == 4'(CUR_OFF) && fit_excl) cur_q <= wdata_i;
      if (w0) begin
        unique case (addr_i)
          OF_START: if (fit_incl) start_q <= wdata_i;
          OF_STOP:  if (fit_incl) stop_q  <= wdata_i;
          OF_BND:   if (fit_excl) bnd_q   <= wdata_i;
          OF_TPG:   tpg_q <= wdata_i;
          OF_TLO:   tcnt_q[7:0]  <= wdata_i;
          OF_THI:   tcnt_q[15:8] <= wdata_i;
          OF_ALO:   rsar_q[7:0]  <= wdata_i;
          OF_AHI:   rsar_q[15:8] <= wdata_i;
          OF_CLO:   rcnt_q[7:0]  <= wdata_i;
          OF_CHI:   rcnt_q[15:8] <= wdata_i;
          OF_RXC:   rxc_q <= wdata_i;
          OF_DCF:   dcf_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_STA; g++) begin : g_sta
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sta_q[g] <= '0;
      else if (w1 && addr_i == 4'(STA_BASE + g)) sta_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < N_HASH; g++) begin : g_hash
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hash_q[g] <= '0;
      else if (w1 && addr_i == 4'(HASH_BASE + g)) hash_q[g] <= wdata_i;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign bnd_o   = bnd_q;
  assign cur_o   = cur_q;
  assign tpg_o   = tpg_q;
  assign tcnt_o  = tcnt_q;
  assign rsar_o  = rsar_q;
  assign rcnt_o  = rcnt_q;
  assign rxc_o   = rxc_q;
  assign dcf_o   = dcf_q;
  assign tsr_o   = tsr_q;
  assign sta_o   = sta_q;
  assign hash_o  = hash_q;
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter byte_t       MEM_END_PG = 8'hC0,
  parameter int unsigned N_STA      = 6,
  parameter int unsigned N_HASH     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [3:0]            addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic [N_EVT-1:0]      evt_i,
  input  logic                  tx_done_i,
  output logic                  tx_start_o,
  output logic                  irq_o,
  output logic [7:0]            cmd_o,
  output logic [7:0]            ring_start_o,
  output logic [7:0]            ring_stop_o,
  output logic [7:0]            ring_bnd_o,
  output logic [7:0]            ring_cur_o,
  output logic [7:0]            tx_page_o,
  output logic [15:0]           tx_len_o,
  output logic [15:0]           rdma_addr_o,
  output logic [15:0]           rdma_len_o,
  output logic [7:0]            rx_cfg_o,
  output logic [7:0]            data_cfg_o,
  output logic [N_STA*8-1:0]    sta_addr_o,
  output logic [N_HASH*8-1:0]   mcast_hash_o
);
  localparam int unsigned CUR_OFF   = STA_BASE + N_STA;
  localparam int unsigned HASH_BASE = CUR_OFF + 1;

  byte_t cmd_w, isr_w, tsr_w;
  page_e page_w;
  logic  cmd_we, reg_we;
  logic [N_EVT-1:0] set_w;
  logic [N_STA-1:0][7:0]  sta_w;
  logic [N_HASH-1:0][7:0] hash_w;

  assign cmd_we = wr_i && (addr_i == 4'h0);
  assign reg_we = wr_i && (addr_i != 4'h0);
  assign page_w = page_e'(cmd_w[7:6]);

  always_comb begin
    set_w = evt_i;
    set_w[IS_TX] = evt_i[IS_TX] | tx_done_i;
  end

  nic_cmd_reg u_cmd (
    .clk_i, .rst_ni,
    .we_i      (cmd_we),
    .wdata_i   (wdata_i),
    .tx_done_i (tx_done_i),
    .cmd_o     (cmd_w),
    .tx_start_o(tx_start_o)
  );

  nic_int_ctl u_int (
    .clk_i, .rst_ni,
    .cmd_we_i    (cmd_we),
    .cmd_wdata_i (wdata_i),
    .rcnt_zero_i (rdma_len_o == '0),
    .clr_we_i    (reg_we && page_w == PG_0 && addr_i == OF_ISR),
    .clr_mask_i  (wdata_i),
    .imr_we_i    (reg_we && page_w == PG_0 && addr_i == OF_IMR),
    .imr_wdata_i (wdata_i),
    .set_i       (set_w),
    .isr_o       (isr_w),
    .irq_o       (irq_o)
  );

  nic_page_regs #(.MEM_END_PG(MEM_END_PG), .N_STA(N_STA), .N_HASH(N_HASH)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we),
    .page_i    (page_w),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .tx_done_i (tx_done_i),
    .start_o   (ring_start_o),
    .stop_o    (ring_stop_o),
    .bnd_o     (ring_bnd_o),
    .cur_o     (ring_cur_o),
    .tpg_o     (tx_page_o),
    .tcnt_o    (tx_len_o),
    .rsar_o    (rdma_addr_o),
    .rcnt_o    (rdma_len_o),
    .rxc_o     (rx_cfg_o),
    .dcf_o     (data_cfg_o),
    .tsr_o     (tsr_w),
    .sta_o     (sta_w),
    .hash_o    (hash_w)
  );

  assign cmd_o        = cmd_w;
  assign sta_addr_o   = sta_w;
  assign mcast_hash_o = hash_w;

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == 4'h0) begin
      rdata_o = cmd_w;
    end else begin
      unique case (page_w)
        PG_0: begin
          unique case (addr_i)
            OF_BND:  rdata_o = ring_bnd_o;
            OF_TPG:  rdata_o = tsr_w;
            OF_ISR:  rdata_o = isr_w;
            OF_ALO:  rdata_o = rdma_addr_o[7:0];
            OF_AHI:  rdata_o = rdma_addr_o[15:8];
            OF_CLO:  rdata_o = ID_LO;
            OF_CHI:  rdata_o = ID_HI;
            default: rdata_o = 8'h00;
          endcase
        end
        PG_1: begin
          for (int k = 0; k < int'(N_STA); k++)
            if (addr_i == 4'(STA_BASE + k)) rdata_o = sta_w[k];
          if (addr_i == 4'(CUR_OFF)) rdata_o = ring_cur_o;
          for (int k = 0; k < int'(N_HASH); k++)
            if (addr_i == 4'(HASH_BASE + k)) rdata_o = hash_w[k];
        end
        PG_2: begin
          if (addr_i == OF_START) rdata_o = ring_start_o;
          if (addr_i == OF_STOP)  rdata_o = ring_stop_o;
        end
        default: rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nic_regbank_chk.sv
module nic_regbank_chk
  import nic_regbank_pkg::*;
#(
  parameter byte_t MEM_END_PG = 8'hC0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [3:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic [N_EVT-1:0] evt_i,
  input logic             tx_done_i,
  input logic             tx_start_o,
  input logic [7:0]       cmd_o,
  input logic [7:0]       isr_i,
  input logic [15:0]      rdma_len_o,
  input logic [7:0]       ring_start_o
);
  p_isr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OF_ISR && cmd_o[7:6] == 2'b00 && wdata_i[6:0] == 7'h7F
     && evt_i == '0 && !tx_done_i) |=> (isr_i[6:0] == 7'h00));

  p_reset_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h0 && !wdata_i[CMD_STOP]) |=> !isr_i[IS_RST]);

  p_rdc_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h0 && !wdata_i[CMD_STOP] && (wdata_i[CMD_RRD] || wdata_i[CMD_RWR])
     && rdma_len_o == 16'h0) |=> isr_i[IS_RDC]);

  p_start_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OF_START && cmd_o[7:6] == 2'b00 && wdata_i > MEM_END_PG)
     |=> $stable(ring_start_o));

  p_tx_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  p_tx_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(wr_i && addr_i == 4'h0 && wdata_i[CMD_TX] && !wdata_i[CMD_STOP]));

  p_evt_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((isr_i[6:0] & $past(evt_i)) == $past(evt_i)));
endmodule

bind nic_regbank nic_regbank_chk #(.MEM_END_PG(MEM_END_PG)) u_chk (
  .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .evt_i, .tx_done_i,
  .tx_start_o, .cmd_o,
  .isr_i (isr_w),
  .rdma_len_o, .ring_start_o
);

// File: tb/nic_regbank_bench.sv
`timescale 1ns/100ps
module nic_regbank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, tx_done = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [6:0] evt = '0;
  logic tx_start, irq;
  logic [7:0] cmd, rs, rp, rb, rc, tp, rxc, dcf;
  logic [15:0] tl, ra, rl;
  logic [47:0] sta;
  logic [63:0] hash;

  int n_chk = 0, n_err = 0, tx_pulses = 0;
  logic rd_probe = 1'b0, irq_probe = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  nic_regbank u_nic_regbank (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .tx_done_i(tx_done), .tx_start_o(tx_start),
    .irq_o(irq), .cmd_o(cmd), .ring_start_o(rs), .ring_stop_o(rp),
    .ring_bnd_o(rb), .ring_cur_o(rc), .tx_page_o(tp), .tx_len_o(tl),
    .rdma_addr_o(ra), .rdma_len_o(rl), .rx_cfg_o(rxc), .data_cfg_o(dcf),
    .sta_addr_o(sta), .mcast_hash_o(hash)
  );

  // monitor: pops expected items at the falling edge
  always @(negedge clk) begin
    if (tx_start) tx_pulses++;
    if (rd_probe || irq_probe) begin
      logic [7:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = rd_probe ? rdata : {7'd0, irq};
      n_chk++;
      if (got !== e) begin
        n_err++;
        $display("FAIL %s: got %02h expected %02h", t, got, e);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
    wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string t);
    addr = a; exp_q.push_back(e); tag_q.push_back(t); rd_probe = 1'b1;
    cyc();
    rd_probe = 1'b0;
  endtask

  task automatic irq_exp(input logic e, input string t);
    exp_q.push_back({7'd0, e}); tag_q.push_back(t); irq_probe = 1'b1;
    cyc();
    irq_probe = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #12 rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd_exp(4'h0, 8'h01, "R1 cmd");
    rd_exp(4'h7, 8'h80, "R1 isr");
    irq_exp(1'b0, "R1 irq");
    // R3 bit 7 not clearable by status write
    wr_reg(4'h7, 8'hFF);
    rd_exp(4'h7, 8'h80, "R3 bit7 kept");
    // R4 bit 7 excluded from irq
    wr_reg(4'hF, 8'h80);
    irq_exp(1'b0, "R4 bit7 masked out");
    // R5
    wr_reg(4'h0, 8'h22);
    rd_exp(4'h7, 8'h00, "R5 reset bit cleared");
    rd_exp(4'h0, 8'h22, "R2 cmd readback");
    // R12 event sets status
    evt = 7'h01; cyc(); evt = '0;
    rd_exp(4'h7, 8'h01, "R12 event set");
    irq_exp(1'b0, "R4 unmasked bit off");
    wr_reg(4'hF, 8'h01);
    irq_exp(1'b1, "R4 irq raised");
    wr_reg(4'h7, 8'h01);
    irq_exp(1'b0, "R3 cleared drops irq");
    rd_exp(4'h7, 8'h00, "R3 w1c");
    evt = 7'h04; addr = 4'h7; wdata = 8'h04; wr = 1'b1; cyc(); wr = 1'b0; evt = '0;
    rd_exp(4'h7, 8'h04, "R12 set beats clear");
    wr_reg(4'h7, 8'h04);
    // R8 byte halves
    wr_reg(4'h8, 8'h34); wr_reg(4'h9, 8'h12);
    rd_exp(4'h8, 8'h34, "R8 addr lo");
    rd_exp(4'h9, 8'h12, "R8 addr hi");
    wr_reg(4'h8, 8'h56);
    rd_exp(4'h9, 8'h12, "R8 hi kept");
    rd_exp(4'h8, 8'h56, "R8 lo updated");
    // R6 zero-count remote DMA shortcut
    wr_reg(4'h0, 8'h0A);
    rd_exp(4'h7, 8'h40, "R6 rdc on zero count");
    wr_reg(4'h7, 8'h40);
    wr_reg(4'hA, 8'h05);
    wr_reg(4'h0, 8'h12);
    rd_exp(4'h7, 8'h00, "R6 nonzero count");
    wr_reg(4'hA, 8'h00);
    wr_reg(4'h0, 8'h09);
    rd_exp(4'h7, 8'h00, "R6 stop set");
    // R7 range checks, R10 page 2 readback
    wr_reg(4'h0, 8'h22);
    wr_reg(4'h1, 8'hC0); wr_reg(4'h1, 8'hC1);
    wr_reg(4'h2, 8'h10); wr_reg(4'h2, 8'hFF);
    wr_reg(4'h3, 8'hC0);
    rd_exp(4'h3, 8'h00, "R7 boundary at end dropped");
    wr_reg(4'h3, 8'hBF);
    rd_exp(4'h3, 8'hBF, "R7 boundary accepted");
    wr_reg(4'h0, 8'h82);
    rd_exp(4'h1, 8'hC0, "R10 R7 start page");
    rd_exp(4'h2, 8'h10, "R10 R7 stop page");
    // R2 page 1
    wr_reg(4'h0, 8'h62);
    wr_reg(4'h7, 8'hC0);
    rd_exp(4'h7, 8'h00, "R7 cur at end dropped");
    wr_reg(4'h7, 8'h05);
    rd_exp(4'h7, 8'h05, "R7 cur accepted");
    wr_reg(4'h1, 8'hAA); wr_reg(4'h6, 8'hBB); wr_reg(4'h8, 8'h5A); wr_reg(4'hF, 8'hA5);
    rd_exp(4'h1, 8'hAA, "R2 sta first");
    rd_exp(4'h6, 8'hBB, "R2 sta last");
    rd_exp(4'h8, 8'h5A, "R2 hash first");
    rd_exp(4'hF, 8'hA5, "R2 hash last");
    wr_reg(4'h0, 8'h22);
    rd_exp(4'h8, 8'h56, "R2 page0 addr untouched");
    irq_exp(1'b0, "R2 mask untouched by page1 write");
    // R9
    rd_exp(4'h1, 8'h00, "R9 undecoded read");
    rd_exp(4'hA, 8'h50, "R9 id lo");
    rd_exp(4'hB, 8'h43, "R9 id hi");
    wr_reg(4'h0, 8'hC2);
    rd_exp(4'h5, 8'h00, "R9 page3");
    // R11 transmit
    wr_reg(4'h0, 8'h26);
    cyc(); cyc();
    n_chk++;
    if (tx_pulses != 1) begin
      n_err++;
      $display("FAIL R11 tx pulses: got %0d expected 1", tx_pulses);
    end
    rd_exp(4'h0, 8'h26, "R11 tx bit held");
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    rd_exp(4'h0, 8'h22, "R11 tx bit cleared");
    rd_exp(4'h4, 8'h01, "R11 tsr");
    rd_exp(4'h7, 8'h02, "R11 tx ok status");
    cyc();
    finish_run();
  end
endmodule